// File: doc/BRIEF.md
# Start-up Supply Sequencer

This block is the digital sequencing core of a high-voltage start-up supply for an off-line switching controller. It receives digitized comparator flags. One flag says the high-voltage input is high enough to feed the start-up current source. A ladder of flags says where the local supply rail (VCC) sits against six levels: inhibit, logic-reset, turn-off, restart, turn-on and overvoltage. A further flag reports thermal shutdown. From these it enables the start-up source, selects its low or high current, tells the rest of the controller when it may switch, and sends a one-cycle clear to the overload fault timer. It also keeps the latched-off state that follows an overvoltage.

The source acts as a hysteretic self-supply. It stops charging once VCC reaches the turn-on level and resumes once VCC sags under the restart level. The first turn-on crossing only arms the controller; switching starts at the following turn-on crossing. A sustained turn-off detection stops switching and clears the fault timer, so a quick unplug and replug restarts cleanly. A sustained overvoltage locks the controller off until VCC collapses below the logic-reset level. Both detections have to persist for a programmable blanking time (`BLANK_CYCLES`, default 1000 cycles, about 10 µs at 100 MHz) before they act.

Top module: `supply_seq`

## Requirements
- R1: `srcEnable` is low in any cycle where `hvOk` is low or `thermalHot` is high. Otherwise it follows the hysteresis state of R2.
- R2: The hysteresis state clears on every clock edge that sees `vccAboveOn` high. It sets on every edge that sees `vccAboveRestart` low while `vccAboveOn` is low. At any other edge it holds its value. It is set by reset.
- R3: From state CHARGE, `vccAboveOn` moves the sequencer to WAIT_SECOND_ON. It enters RUN only on a later edge with `vccAboveOn` high that follows an edge with `vccAboveOn` low. `runActive` is high exactly in RUN.
- R4: `srcHighCurrent` equals `vccAboveInhibit` in every cycle: 0 selects the low start-up current and 1 selects the high current.
- R5: A confirmed turn-off detection (`vccAboveOff` low) in WAIT_SECOND_ON or RUN returns the sequencer to CHARGE. In the same cycle as that change it raises `faultClearPulse` for exactly one cycle.
- R6: A turn-off or overvoltage detection counts as confirmed only once it has been seen on `BLANK_CYCLES` consecutive clock edges. A single edge without the detection restarts the count.
- R7: A confirmed overvoltage (`vccAboveOvp` high) in CHARGE, WAIT_SECOND_ON or RUN enters LATCHED and sets `ovpLatched`. The only exit is `vccAboveReset` going low, which returns to RESET and clears `ovpLatched`.
- R8: `thermalHot` forces RESET from any state except LATCHED. The sequencer stays in RESET while the flag is set.
- R9: After `rstN` low, or on any edge that sees `vccAboveReset` low, the state is RESET. From RESET the sequencer moves to CHARGE on the first edge with `vccAboveReset` high and `thermalHot` low.
- R10: `stateDbg` encodes the state as RESET=0, CHARGE=1, WAIT_SECOND_ON=2, RUN=3, LATCHED=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hvOk | input | 1 | High-voltage input is above the minimum needed by the start-up source |
| vccAboveInhibit | input | 1 | VCC is above the low-current inhibit level |
| vccAboveReset | input | 1 | VCC is above the logic-reset level |
| vccAboveOff | input | 1 | VCC is above the turn-off level |
| vccAboveRestart | input | 1 | VCC is above the source restart level |
| vccAboveOn | input | 1 | VCC is at or above the turn-on level |
| vccAboveOvp | input | 1 | VCC is above the overvoltage level |
| thermalHot | input | 1 | Thermal shutdown is flagged |
| srcEnable | output | 1 | Start-up current source enable |
| srcHighCurrent | output | 1 | 1 selects the high start-up current, 0 the low one |
| runActive | output | 1 | The controller may switch |
| faultClearPulse | output | 1 | One-cycle clear for the overload fault timer |
| ovpLatched | output | 1 | Overvoltage latch-off is held |
| stateDbg | output | 3 | Current sequencer state (R10 encoding) |

## Verification
The assertions assume that the VCC flags form a consistent ladder. A flag for a higher level is never set while a flag for a lower level is clear, because one rail is compared against ordered thresholds. The bench drives VCC only through a single level index that sets every flag from this ladder at once, so the stimulus cannot create a contradictory combination. The blanking-window assertions also assume that the flags change only between clock edges. The bench meets this by driving all inputs shortly after each rising edge.

// File: rtl/supply_seq_pkg.sv
package supply_seq_pkg;

  typedef enum logic [2:0] {
    ST_RESET      = 3'd0,
    ST_CHARGE     = 3'd1,
    ST_WAIT_ON    = 3'd2,
    ST_RUN        = 3'd3,
    ST_LATCHED    = 3'd4
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic setOvp;
    logic clrOvp;
    logic fireFaultClr;
  } dpStrobe_t;

  // confirmed detections from datapath to control
  typedef struct packed {
    logic offConfirmed;
    logic ovpConfirmed;
  } dpStatus_t;

  localparam int NUM_BLANKERS = 2;
  localparam int BLANK_OFF_IDX = 0;
  localparam int BLANK_OVP_IDX = 1;

endpackage

// File: rtl/supply_seq_blank.sv
module supply_seq_blank #(
  parameter int BLANK_CYCLES = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic detect,
  output logic confirmed
);
  localparam int CW = $clog2(BLANK_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(BLANK_CYCLES);

  logic [CW-1:0] persistCnt;

  // consecutive-edge persistence counter, saturating at the limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      persistCnt <= '0;
    end else if (!detect) begin
      persistCnt <= '0;
    end else if (persistCnt != LIMIT) begin
      persistCnt <= persistCnt + 1'b1;
    end
  end

  assign confirmed = (persistCnt == LIMIT);
endmodule

// File: rtl/supply_seq_dp.sv
module supply_seq_dp
  import supply_seq_pkg::*;
#(
  parameter int BLANK_CYCLES = 1000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      hvOk,
  input  logic      thermalHot,
  input  logic      vccAboveInhibit,
  input  logic      vccAboveOff,
  input  logic      vccAboveRestart,
  input  logic      vccAboveOn,
  input  logic      vccAboveOvp,
  input  dpStrobe_t strobe,
  output dpStatus_t status,
  output logic      srcEnable,
  output logic      srcHighCurrent,
  output logic      ovpLatched,
  output logic      faultClearPulse
);
  logic [NUM_BLANKERS-1:0] detectVec;
  logic [NUM_BLANKERS-1:0] confVec;
  logic topUpReq;
  logic ovpQ;
  logic fclrQ;

  assign detectVec[BLANK_OFF_IDX] = ~vccAboveOff;
  assign detectVec[BLANK_OVP_IDX] = vccAboveOvp;

  for (genvar g = 0; g < NUM_BLANKERS; g++) begin : gBlank
    supply_seq_blank #(
      .BLANK_CYCLES(BLANK_CYCLES)
    ) blankU (
      .clk      (clk),
      .rstN     (rstN),
      .detect   (detectVec[g]),
      .confirmed(confVec[g])
    );
  end

  assign status.offConfirmed = confVec[BLANK_OFF_IDX];
  assign status.ovpConfirmed = confVec[BLANK_OVP_IDX];

  // self-supply hysteresis: stop at turn-on, resume below restart
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      topUpReq <= 1'b1;
    end else if (vccAboveOn) begin
      topUpReq <= 1'b0;
    end else if (!vccAboveRestart) begin
      topUpReq <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovpQ  <= 1'b0;
      fclrQ <= 1'b0;
    end else begin
      fclrQ <= strobe.fireFaultClr;
      if (strobe.clrOvp) begin
        ovpQ <= 1'b0;
      end else if (strobe.setOvp) begin
        ovpQ <= 1'b1;
      end
    end
  end

  assign srcEnable       = topUpReq & hvOk & ~thermalHot;
  assign srcHighCurrent  = vccAboveInhibit;
  assign ovpLatched      = ovpQ;
  assign faultClearPulse = fclrQ;
endmodule

// File: rtl/supply_seq_ctrl.sv
module supply_seq_ctrl
  import supply_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      vccAboveReset,
  input  logic      vccAboveOn,
  input  logic      thermalHot,
  input  dpStatus_t status,
  output dpStrobe_t strobe,
  output seqState_t state
);
  seqState_t stateNxt;
  logic seenLow;
  logic seenLowNxt;

  always_comb begin
    stateNxt   = state;
    seenLowNxt = seenLow;
    strobe     = '0;
    if (!vccAboveReset) begin
      stateNxt      = ST_RESET;
      strobe.clrOvp = 1'b1;
    end else if (thermalHot && (state != ST_LATCHED)) begin
      stateNxt = ST_RESET;
    end else begin
      case (state)
        ST_RESET: stateNxt = ST_CHARGE;
        ST_CHARGE: begin
          if (status.ovpConfirmed) begin
            stateNxt      = ST_LATCHED;
            strobe.setOvp = 1'b1;
          end else if (vccAboveOn) begin
            stateNxt   = ST_WAIT_ON;
            seenLowNxt = 1'b0;
          end
        end
        ST_WAIT_ON: begin
          if (status.ovpConfirmed) begin
            stateNxt      = ST_LATCHED;
            strobe.setOvp = 1'b1;
          end else if (status.offConfirmed) begin
            stateNxt            = ST_CHARGE;
            strobe.fireFaultClr = 1'b1;
          end else if (vccAboveOn && seenLow) begin
            stateNxt = ST_RUN;
          end else if (!vccAboveOn) begin
            seenLowNxt = 1'b1;
          end
        end
        ST_RUN: begin
          if (status.ovpConfirmed) begin
            stateNxt      = ST_LATCHED;
            strobe.setOvp = 1'b1;
          end else if (status.offConfirmed) begin
            stateNxt            = ST_CHARGE;
            strobe.fireFaultClr = 1'b1;
          end
        end
        ST_LATCHED: stateNxt = ST_LATCHED;
        default:    stateNxt = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_RESET;
      seenLow <= 1'b0;
    end else begin
      state   <= stateNxt;
      seenLow <= seenLowNxt;
    end
  end
endmodule

// File: rtl/supply_seq.sv
module supply_seq
  import supply_seq_pkg::*;
#(
  parameter int BLANK_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hvOk,
  input  logic       vccAboveInhibit,
  input  logic       vccAboveReset,
  input  logic       vccAboveOff,
  input  logic       vccAboveRestart,
  input  logic       vccAboveOn,
  input  logic       vccAboveOvp,
  input  logic       thermalHot,
  output logic       srcEnable,
  output logic       srcHighCurrent,
  output logic       runActive,
  output logic       faultClearPulse,
  output logic       ovpLatched,
  output logic [2:0] stateDbg
);
  dpStrobe_t strobe;
  dpStatus_t status;
  seqState_t state;

  supply_seq_ctrl ctrlU (
    .clk          (clk),
    .rstN         (rstN),
    .vccAboveReset(vccAboveReset),
    .vccAboveOn   (vccAboveOn),
    .thermalHot   (thermalHot),
    .status       (status),
    .strobe       (strobe),
    .state        (state)
  );

  supply_seq_dp #(
    .BLANK_CYCLES(BLANK_CYCLES)
  ) dpU (
    .clk            (clk),
    .rstN           (rstN),
    .hvOk           (hvOk),
    .thermalHot     (thermalHot),
    .vccAboveInhibit(vccAboveInhibit),
    .vccAboveOff    (vccAboveOff),
    .vccAboveRestart(vccAboveRestart),
    .vccAboveOn     (vccAboveOn),
    .vccAboveOvp    (vccAboveOvp),
    .strobe         (strobe),
    .status         (status),
    .srcEnable      (srcEnable),
    .srcHighCurrent (srcHighCurrent),
    .ovpLatched     (ovpLatched),
    .faultClearPulse(faultClearPulse)
  );

  assign runActive = (state == ST_RUN);
  assign stateDbg  = state;
endmodule

// File: rtl/supply_seq_chk.sv
module supply_seq_chk #(
  parameter int BLANK_CYCLES = 1000
) (
  input logic clk,
  input logic rstN,
  input logic hvOk,
  input logic vccAboveReset,
  input logic vccAboveOff,
  input logic vccAboveRestart,
  input logic vccAboveOn,
  input logic vccAboveOvp,
  input logic thermalHot,
  input logic srcEnable,
  input logic runActive,
  input logic faultClearPulse,
  input logic ovpLatched
);
  localparam int CW = $clog2(BLANK_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(BLANK_CYCLES);

  logic [CW-1:0] lowRun;
  logic [CW-1:0] highRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun  <= '0;
      highRun <= '0;
    end else begin
      if (vccAboveOff) lowRun <= '0;
      else if (lowRun < LIMIT) lowRun <= lowRun + 1'b1;
      if (!vccAboveOvp) highRun <= '0;
      else if (highRun < LIMIT) highRun <= highRun + 1'b1;
    end
  end

  AST_SRC_STOPS_AT_ON: assert property (@(posedge clk) disable iff (!rstN)
    vccAboveOn |=> !srcEnable); // R2

  AST_SRC_RESUMES_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!vccAboveRestart && !vccAboveOn) |=> (srcEnable || !hvOk || thermalHot)); // R2

  AST_RUN_ON_CROSSING: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runActive) |-> $past(vccAboveOn)); // R3

  AST_FCLR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    faultClearPulse |=> !faultClearPulse); // R5

  AST_FCLR_BLANKED: assert property (@(posedge clk) disable iff (!rstN)
    faultClearPulse |-> ($past(lowRun) >= LIMIT)); // R6

  AST_OVP_BLANKED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovpLatched) |-> ($past(highRun) >= LIMIT)); // R6

  AST_OVP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovpLatched && vccAboveReset) |=> ovpLatched); // R7

  AST_NO_RUN_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    ovpLatched |-> !runActive); // R7

  AST_THERMAL_STOP: assert property (@(posedge clk) disable iff (!rstN)
    thermalHot |=> !runActive); // R8
endmodule

bind supply_seq supply_seq_chk #(
  .BLANK_CYCLES(BLANK_CYCLES)
) chkU (
  .clk            (clk),
  .rstN           (rstN),
  .hvOk           (hvOk),
  .vccAboveReset  (vccAboveReset),
  .vccAboveOff    (vccAboveOff),
  .vccAboveRestart(vccAboveRestart),
  .vccAboveOn     (vccAboveOn),
  .vccAboveOvp    (vccAboveOvp),
  .thermalHot     (thermalHot),
  .srcEnable      (srcEnable),
  .runActive      (runActive),
  .faultClearPulse(faultClearPulse),
  .ovpLatched     (ovpLatched)
);

// File: tb/supply_seq_tb_top.sv
module supply_seq_tb_top;
  localparam int B = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hvOk = 1'b0;
  logic vInh = 1'b0, vRst = 1'b0, vOff = 1'b0, vRes = 1'b0, vOn = 1'b0, vOvp = 1'b0;
  logic thermalHot = 1'b0;
  logic srcEnable, srcHighCurrent, runActive, faultClearPulse, ovpLatched;
  logic [2:0] stateDbg;

  int total = 0;
  int bad = 0;
  int pulseSeen = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  supply_seq #(.BLANK_CYCLES(B)) dut_i (
    .clk(clk), .rstN(rstN), .hvOk(hvOk),
    .vccAboveInhibit(vInh), .vccAboveReset(vRst), .vccAboveOff(vOff),
    .vccAboveRestart(vRes), .vccAboveOn(vOn), .vccAboveOvp(vOvp),
    .thermalHot(thermalHot),
    .srcEnable(srcEnable), .srcHighCurrent(srcHighCurrent), .runActive(runActive),
    .faultClearPulse(faultClearPulse), .ovpLatched(ovpLatched), .stateDbg(stateDbg)
  );

  // behavioural reference model
  int mState = 0;
  bit mHyst = 1'b1;
  int mOffCnt = 0;
  int mOvpCnt = 0;
  bit mSeenLow = 1'b0;
  bit mOvp = 1'b0;
  bit mFclr = 1'b0;
  bit offC, ovpC;

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mHyst = 1'b1; mOffCnt = 0; mOvpCnt = 0;
      mSeenLow = 1'b0; mOvp = 1'b0; mFclr = 1'b0;
    end else begin
      offC = (mOffCnt == B);
      ovpC = (mOvpCnt == B);
      mFclr = 1'b0;
      if (!vRst) begin
        mState = 0; mOvp = 1'b0;
      end else if (thermalHot && mState != 4) begin
        mState = 0;
      end else if (mState == 0) begin
        mState = 1;
      end else if (mState != 4 && ovpC) begin
        mState = 4; mOvp = 1'b1;
      end else if (mState == 1) begin
        if (vOn) begin mState = 2; mSeenLow = 1'b0; end
      end else if ((mState == 2 || mState == 3) && offC) begin
        mState = 1; mFclr = 1'b1;
      end else if (mState == 2) begin
        if (vOn && mSeenLow) mState = 3;
        else if (!vOn) mSeenLow = 1'b1;
      end
      if (vOn) mHyst = 1'b0;
      else if (!vRes) mHyst = 1'b1;
      if (vOff) mOffCnt = 0; else if (mOffCnt < B) mOffCnt++;
      if (!vOvp) mOvpCnt = 0; else if (mOvpCnt < B) mOvpCnt++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare against the model on every clock
  always @(negedge clk) begin
    if (!finished) begin
      check(srcEnable == (mHyst && hvOk && !thermalHot), "R1 srcEnable", srcEnable, mHyst && hvOk && !thermalHot);
      check(srcHighCurrent == vInh, "R4 srcHighCurrent", srcHighCurrent, vInh);
      check(runActive == (mState == 3), "R3 runActive", runActive, mState == 3);
      check(faultClearPulse == mFclr, "R5 faultClearPulse", faultClearPulse, mFclr);
      check(ovpLatched == mOvp, "R7 ovpLatched", ovpLatched, mOvp);
      check(int'(stateDbg) == mState, "R10 stateDbg", stateDbg, mState);
      if (faultClearPulse) pulseSeen++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // ladder: 1 inhibit, 2 reset, 3 off, 4 restart, 5 on, 6 ovp
  task automatic setVcc(input int lvl);
    vInh = (lvl >= 1); vRst = (lvl >= 2); vOff = (lvl >= 3);
    vRes = (lvl >= 4); vOn = (lvl >= 5); vOvp = (lvl >= 6);
  endtask

  task automatic reachRun();
    setVcc(5); tick(2);
    setVcc(3); tick(2);
    setVcc(5); tick(2);
  endtask

  task automatic finish_up();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    int p0;
    tick(3);
    check(stateDbg == 3'd0, "R9 reset state", stateDbg, 0);
    check(srcEnable == 1'b0, "R1 no HV no source", srcEnable, 0);
    rstN = 1'b1; tick(2);
    hvOk = 1'b1; setVcc(0); tick(1);
    check(srcEnable == 1'b1, "R1 source on at power-up", srcEnable, 1);
    check(srcHighCurrent == 1'b0, "R4 low current near ground", srcHighCurrent, 0);
    setVcc(1); tick(2);
    check(srcHighCurrent == 1'b1, "R4 high current above inhibit", srcHighCurrent, 1);
    check(stateDbg == 3'd0, "R9 held below reset level", stateDbg, 0);
    setVcc(2); tick(2);
    check(stateDbg == 3'd1, "R9 enters CHARGE", stateDbg, 1);
    setVcc(4); tick(2); setVcc(5); tick(2);
    check(stateDbg == 3'd2, "R3 first crossing waits", stateDbg, 2);
    check(srcEnable == 1'b0, "R2 source off at turn-on", srcEnable, 0);
    setVcc(4); tick(3);
    check(srcEnable == 1'b0, "R2 source held off in band", srcEnable, 0);
    setVcc(3); tick(2);
    check(srcEnable == 1'b1, "R2 source back below restart", srcEnable, 1);
    check(runActive == 1'b0, "R3 not yet running", runActive, 0);
    setVcc(5); tick(2);
    check(runActive == 1'b1, "R3 second crossing runs", runActive, 1);

    p0 = pulseSeen;
    setVcc(2); tick(B - 5); setVcc(5); tick(2);
    check(runActive == 1'b1, "R6 short turn-off ignored", runActive, 1);
    check(pulseSeen == p0, "R6 no clear on short dip", pulseSeen, p0);
    setVcc(2); tick(B + 3);
    check(stateDbg == 3'd1, "R5 turn-off back to CHARGE", stateDbg, 1);
    check(pulseSeen == p0 + 1, "R5 one fault clear pulse", pulseSeen, p0 + 1);

    reachRun();
    check(runActive == 1'b1, "R3 run again", runActive, 1);
    thermalHot = 1'b1; tick(2);
    check(stateDbg == 3'd0, "R8 thermal forces RESET", stateDbg, 0);
    setVcc(3); tick(2);
    check(srcEnable == 1'b0, "R8 source off when hot", srcEnable, 0);
    thermalHot = 1'b0; tick(2);
    check(stateDbg == 3'd1, "R8 resumes CHARGE", stateDbg, 1);
    check(srcEnable == 1'b1, "R1 source on after cooling", srcEnable, 1);
    hvOk = 1'b0; tick(1);
    check(srcEnable == 1'b0, "R1 low HV blocks source", srcEnable, 0);
    hvOk = 1'b1;

    reachRun();
    setVcc(6); tick(B - 3); setVcc(5); tick(2);
    check(ovpLatched == 1'b0, "R6 short overvoltage ignored", ovpLatched, 0);
    setVcc(6); tick(B + 3);
    check(ovpLatched == 1'b1, "R7 overvoltage latches", ovpLatched, 1);
    check(stateDbg == 3'd4, "R7 LATCHED code", stateDbg, 4);
    setVcc(3); tick(3);
    check(ovpLatched == 1'b1, "R7 latch survives turn-off", ovpLatched, 1);
    check(srcEnable == 1'b1, "R2 self-supply while latched", srcEnable, 1);
    thermalHot = 1'b1; tick(2);
    check(stateDbg == 3'd4, "R8 thermal keeps LATCHED", stateDbg, 4);
    thermalHot = 1'b0;
    setVcc(5); tick(2);
    check(runActive == 1'b0, "R7 no restart while latched", runActive, 0);
    setVcc(1); tick(2);
    check(ovpLatched == 1'b0, "R7 released below reset", ovpLatched, 0);
    check(stateDbg == 3'd0, "R9 RESET below reset level", stateDbg, 0);
    finish_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end
endmodule